// File: doc/BRIEF.md
# Programmable Video Gating and Cursor Generator

This block derives two general-purpose timing outputs from a running video raster. It counts pixel clocks from each line-start strobe and counts lines from each frame-start strobe. It compares both positions against programmed start and width values, giving three windows: a horizontal gate measured in pixels, a vertical gate measured in lines, and a vertical interrupt window measured in lines. Each window opens at its start position and stays open for its width.

A mode input selects what the two drive pins carry. With the mode low they carry the plain horizontal and vertical gates. With the mode high the first pin carries a cursor, which is the horizontal gate qualified by the vertical gate and so gives one pulse per line inside the vertical window. The second pin then carries the vertical interrupt. A polarity input selects active-high or active-low outputs. When the composite sync and blank output mode is not selected, both pins rest at their inactive level. The vertical windows are sampled only at line starts, which is the point where vertical blanking changes.

Top module: `video_gate_gen`

## Requirements
- R1: While reset is asserted and just after it, both outputs sit at the inactive level: 0 when activeLow is 0, and 1 when activeLow is 1.
- R2: The cycle in which lineStart is 1 is pixel 0, and each following cycle is the next pixel. The horizontal gate is active for pixel p when hStart <= p < hStart + hWidth. driveH shows the state for pixel p in the cycle after pixel p.
- R3: The line whose lineStart coincides with frameStart is line 0, and each later lineStart advances the line number by one. The vertical gate is active on lines vStart <= L < vStart + vWidth.
- R4: The vertical gate and the interrupt change state only at a lineStart. A change of vStart or irqStart in the middle of a line has no effect until the next line begins.
- R5: With cursorMode = 1, driveH carries the cursor, which is active only while both the horizontal and vertical gates are active. driveV carries the vertical interrupt.
- R6: The vertical interrupt is active on lines irqStart <= L < irqStart + irqWidth.
- R7: A width value of 0 suppresses its window completely.
- R8: With activeLow = 1, every output is inverted. The cursor is then formed as the OR of the active-low gates.
- R9: With compositeMode = 0, both outputs stay at the inactive level whatever the counters and registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStart | input | 1 | One-cycle strobe marking pixel 0 of a line |
| frameStart | input | 1 | Together with lineStart, marks line 0 of a frame |
| compositeMode | input | 1 | Composite sync and blank output mode selected |
| cursorMode | input | 1 | 0: gates; 1: cursor and vertical interrupt |
| activeLow | input | 1 | Output polarity: 1 selects active low |
| hStart | input | 16 | First pixel of the horizontal gate |
| hWidth | input | 16 | Horizontal gate width in pixels |
| vStart | input | 16 | First line of the vertical gate |
| vWidth | input | 16 | Vertical gate width in lines |
| irqStart | input | 16 | First line of the vertical interrupt |
| irqWidth | input | 16 | Vertical interrupt width in lines |
| driveH | output | 1 | Horizontal gate or cursor |
| driveV | output | 1 | Vertical gate or vertical interrupt |

## Verification
The hardest case to produce is a line-window register that changes while a line is in progress. The ports must then show that the vertical state stays unchanged until the next line start. The bench rewrites vStart and irqStart in the middle of a line inside the window. During the same line it switches into cursor mode so that the interrupt becomes visible. It then checks that both outputs hold for the rest of that line and settle to the new values only from the following line start. A table of window settings also exercises the cursor AND and OR forms, zero widths, and horizontal windows that run past the end of a line.

// File: rtl/video_gate_pkg.sv
`timescale 1ns/1ps
package video_gate_pkg;

  typedef enum logic [1:0] {
    OUT_IDLE   = 2'd0,
    OUT_GATES  = 2'd1,
    OUT_CURSOR = 2'd2
  } outSel_e;

  typedef struct packed {
    logic    lineGo;
    outSel_e outSel;
  } gateStrobe_t;

endpackage

// File: rtl/gate_timing_ctrl.sv
`timescale 1ns/1ps
module gate_timing_ctrl #(
  parameter int POS_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            lineStart,
  input  logic                            frameStart,
  input  logic                            compositeMode,
  input  logic                            cursorMode,
  output logic [POS_W-1:0]                pixIdx,
  output logic [POS_W-1:0]                lineIdx,
  output video_gate_pkg::gateStrobe_t     strb
);
  import video_gate_pkg::*;

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pixCnt;
  logic [POS_W-1:0] lineCnt;

  // current pixel and line positions (saturating)
  always_comb begin
    if (lineStart) begin
      pixIdx = '0;
    end else if (pixCnt == POS_MAX) begin
      pixIdx = pixCnt;
    end else begin
      pixIdx = POS_W'(pixCnt + 1'b1);
    end

    if (!lineStart) begin
      lineIdx = lineCnt;
    end else if (frameStart) begin
      lineIdx = '0;
    end else if (lineCnt == POS_MAX) begin
      lineIdx = lineCnt;
    end else begin
      lineIdx = POS_W'(lineCnt + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else begin
      pixCnt  <= pixIdx;
      lineCnt <= lineIdx;
    end
  end

  // output mode decode and strobes
  always_comb begin
    strb.lineGo = lineStart;
    if (!compositeMode) begin
      strb.outSel = OUT_IDLE;
    end else if (cursorMode) begin
      strb.outSel = OUT_CURSOR;
    end else begin
      strb.outSel = OUT_GATES;
    end
  end

endmodule

// File: rtl/span_match.sv
`timescale 1ns/1ps
module span_match #(
  parameter int POS_W = 16
) (
  input  logic [POS_W-1:0] idx,
  input  logic [POS_W-1:0] start,
  input  logic [POS_W-1:0] width,
  output logic             hit
);
  logic [POS_W-1:0] offs;

  always_comb begin
    offs = idx - start;
    hit  = (idx >= start) && (offs < width);
  end

endmodule

// File: rtl/gate_datapath.sv
`timescale 1ns/1ps
module gate_datapath #(
  parameter int POS_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  video_gate_pkg::gateStrobe_t  strb,
  input  logic [POS_W-1:0]             pixIdx,
  input  logic [POS_W-1:0]             lineIdx,
  input  logic                         activeLow,
  input  logic [POS_W-1:0]             hStart,
  input  logic [POS_W-1:0]             hWidth,
  input  logic [POS_W-1:0]             vStart,
  input  logic [POS_W-1:0]             vWidth,
  input  logic [POS_W-1:0]             irqStart,
  input  logic [POS_W-1:0]             irqWidth,
  output logic                         driveH,
  output logic                         driveV
);
  import video_gate_pkg::*;

  localparam int NUM_SPAN = 3;
  localparam int SPAN_H   = 0;
  localparam int SPAN_V   = 1;
  localparam int SPAN_IRQ = 2;

  logic [NUM_SPAN-1:0][POS_W-1:0] spanIdx;
  logic [NUM_SPAN-1:0][POS_W-1:0] spanStart;
  logic [NUM_SPAN-1:0][POS_W-1:0] spanWidth;
  logic [NUM_SPAN-1:0]            spanHit;

  assign spanIdx   = {lineIdx,  lineIdx, pixIdx};
  assign spanStart = {irqStart, vStart,  hStart};
  assign spanWidth = {irqWidth, vWidth,  hWidth};

  for (genvar g = 0; g < NUM_SPAN; g++) begin : gSpan
    span_match #(.POS_W(POS_W)) uSpan (
      .idx   (spanIdx[g]),
      .start (spanStart[g]),
      .width (spanWidth[g]),
      .hit   (spanHit[g])
    );
  end

  logic hOn;
  logic vOn;
  logic irqOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hOn   <= 1'b0;
      vOn   <= 1'b0;
      irqOn <= 1'b0;
    end else begin
      hOn <= spanHit[SPAN_H];
      if (strb.lineGo) begin
        vOn   <= spanHit[SPAN_V];
        irqOn <= spanHit[SPAN_IRQ];
      end
    end
  end

  logic actH;
  logic actV;
  logic curLow;

  always_comb begin
    curLow = (~hOn) | (~vOn);
    actH   = 1'b0;
    actV   = 1'b0;
    case (strb.outSel)
      OUT_GATES: begin
        actH = hOn;
        actV = vOn;
      end
      OUT_CURSOR: begin
        actH = activeLow ? ~curLow : (hOn & vOn);
        actV = irqOn;
      end
      default: begin
        actH = 1'b0;
        actV = 1'b0;
      end
    endcase
    driveH = actH ^ activeLow;
    driveV = actV ^ activeLow;
  end

endmodule

// File: rtl/video_gate_gen.sv
`timescale 1ns/1ps
module video_gate_gen #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             frameStart,
  input  logic             compositeMode,
  input  logic             cursorMode,
  input  logic             activeLow,
  input  logic [POS_W-1:0] hStart,
  input  logic [POS_W-1:0] hWidth,
  input  logic [POS_W-1:0] vStart,
  input  logic [POS_W-1:0] vWidth,
  input  logic [POS_W-1:0] irqStart,
  input  logic [POS_W-1:0] irqWidth,
  output logic             driveH,
  output logic             driveV
);
  import video_gate_pkg::*;

  gateStrobe_t      strb;
  logic [POS_W-1:0] pixIdx;
  logic [POS_W-1:0] lineIdx;

  gate_timing_ctrl #(.POS_W(POS_W)) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .lineStart     (lineStart),
    .frameStart    (frameStart),
    .compositeMode (compositeMode),
    .cursorMode    (cursorMode),
    .pixIdx        (pixIdx),
    .lineIdx       (lineIdx),
    .strb          (strb)
  );

  gate_datapath #(.POS_W(POS_W)) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pixIdx    (pixIdx),
    .lineIdx   (lineIdx),
    .activeLow (activeLow),
    .hStart    (hStart),
    .hWidth    (hWidth),
    .vStart    (vStart),
    .vWidth    (vWidth),
    .irqStart  (irqStart),
    .irqWidth  (irqWidth),
    .driveH    (driveH),
    .driveV    (driveV)
  );

endmodule

// File: rtl/video_gate_gen_chk.sv
`timescale 1ns/1ps
module video_gate_gen_chk #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             lineStart,
  input logic             frameStart,
  input logic             compositeMode,
  input logic             cursorMode,
  input logic             activeLow,
  input logic [POS_W-1:0] hStart,
  input logic [POS_W-1:0] hWidth,
  input logic [POS_W-1:0] vStart,
  input logic [POS_W-1:0] vWidth,
  input logic             driveH,
  input logic             driveV
);

  // R9
  idle_when_not_composite_chk: assert property (@(posedge clk) disable iff (!rstN)
    !compositeMode |-> (driveH == activeLow) && (driveV == activeLow));

  // R4
  vert_holds_midline_chk: assert property (@(posedge clk) disable iff (!rstN)
    (compositeMode && !cursorMode && !lineStart) |=>
      (!compositeMode || cursorMode || !$stable(activeLow) || $stable(driveV)));

  // R2
  pixel_zero_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(lineStart) && compositeMode && !cursorMode) |->
      (driveH == ($past((hStart == '0) && (hWidth != '0)) ^ activeLow)));

  // R7
  zero_width_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(hWidth == '0) && compositeMode && !cursorMode) |->
      (driveH == activeLow));

  // R3
  line_zero_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN && lineStart && frameStart) && compositeMode && !cursorMode) |->
      (driveV == ($past((vStart == '0) && (vWidth != '0)) ^ activeLow)));

endmodule

bind video_gate_gen video_gate_gen_chk #(.POS_W(POS_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .lineStart     (lineStart),
  .frameStart    (frameStart),
  .compositeMode (compositeMode),
  .cursorMode    (cursorMode),
  .activeLow     (activeLow),
  .hStart        (hStart),
  .hWidth        (hWidth),
  .vStart        (vStart),
  .vWidth        (vWidth),
  .driveH        (driveH),
  .driveV        (driveV)
);

// File: tb/video_gate_gen_bench.sv
`timescale 1ns/1ps
module video_gate_gen_bench;

  localparam int LINE_LEN  = 12;
  localparam int FRAME_LNS = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic        frameStart = 1'b0;
  logic        compositeMode = 1'b1;
  logic        cursorMode = 1'b0;
  logic        activeLow = 1'b0;
  logic [15:0] hStart = '0, hWidth = '0, vStart = '0, vWidth = '0;
  logic [15:0] irqStart = '0, irqWidth = '0;
  logic        driveH, driveV;

  always #2.5 clk = ~clk;

  video_gate_gen u_video_gate_gen (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .compositeMode(compositeMode), .cursorMode(cursorMode), .activeLow(activeLow),
    .hStart(hStart), .hWidth(hWidth), .vStart(vStart), .vWidth(vWidth),
    .irqStart(irqStart), .irqWidth(irqWidth), .driveH(driveH), .driveV(driveV)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int mPix = 0, mLine = 0;
  bit mH = 0, mV = 0, mI = 0;

  function automatic bit inSpan(int idx, int s, int w);
    return (idx >= s) && (idx < s + w);
  endfunction

  task automatic tick();
    if (rstN) begin
      if (lineStart) begin
        mPix  = 0;
        mLine = frameStart ? 0 : ((mLine < 65535) ? mLine + 1 : mLine);
        mV    = inSpan(mLine, int'(vStart), int'(vWidth));
        mI    = inSpan(mLine, int'(irqStart), int'(irqWidth));
      end else if (mPix < 65535) begin
        mPix = mPix + 1;
      end
      mH = inSpan(mPix, int'(hStart), int'(hWidth));
    end else begin
      mPix = 0; mLine = 0; mH = 0; mV = 0; mI = 0;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag);
    bit aH, aV, eH, eV;
    if (!compositeMode) begin
      aH = 0; aV = 0;
    end else if (cursorMode) begin
      aH = mH & mV; aV = mI;
    end else begin
      aH = mH; aV = mV;
    end
    eH = aH ^ activeLow;
    eV = aV ^ activeLow;
    checks++;
    if (driveH !== eH || driveV !== eV) begin
      fails++;
      $display("FAIL %s: driveH/driveV = %b/%b expected %b/%b (line %0d pixel %0d)",
               tag, driveH, driveV, eH, eV, mLine, mPix);
    end
  endtask

  task automatic runFrames(int nFrames, string tag);
    for (int f = 0; f < nFrames; f++) begin
      for (int l = 0; l < FRAME_LNS; l++) begin
        for (int k = 0; k < LINE_LEN; k++) begin
          lineStart  = (k == 0);
          frameStart = (k == 0) && (l == 0);
          tick();
          check(tag);
        end
      end
    end
    lineStart  = 0;
    frameStart = 0;
  endtask

  typedef struct packed {
    logic [15:0] hs, hw, vs, vw, is, iw;
    logic        cur, low;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{hs:16'd2,  hw:16'd3,  vs:16'd1, vw:16'd2, is:16'd0, iw:16'd1, cur:1'b0, low:1'b0, req:4'd2},
    '{hs:16'd0,  hw:16'd12, vs:16'd3, vw:16'd3, is:16'd2, iw:16'd1, cur:1'b0, low:1'b0, req:4'd3},
    '{hs:16'd4,  hw:16'd2,  vs:16'd2, vw:16'd2, is:16'd4, iw:16'd2, cur:1'b1, low:1'b0, req:4'd5},
    '{hs:16'd4,  hw:16'd2,  vs:16'd2, vw:16'd2, is:16'd4, iw:16'd2, cur:1'b1, low:1'b1, req:4'd8},
    '{hs:16'd5,  hw:16'd0,  vs:16'd0, vw:16'd0, is:16'd1, iw:16'd0, cur:1'b0, low:1'b0, req:4'd7},
    '{hs:16'd0,  hw:16'd1,  vs:16'd0, vw:16'd6, is:16'd1, iw:16'd3, cur:1'b1, low:1'b0, req:4'd6},
    '{hs:16'd10, hw:16'd5,  vs:16'd5, vw:16'd9, is:16'd0, iw:16'd2, cur:1'b0, low:1'b1, req:4'd8}
  };

  function automatic string tagOf(logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset level for both polarities
    rstN = 0; activeLow = 0;
    tick(); tick();
    check("R1");
    activeLow = 1;
    tick();
    check("R1");
    activeLow = 0;
    rstN = 1;
    tick();
    check("R1");

    // table of window settings
    for (int v = 0; v < NVEC; v++) begin
      hStart = VECS[v].hs; hWidth = VECS[v].hw;
      vStart = VECS[v].vs; vWidth = VECS[v].vw;
      irqStart = VECS[v].is; irqWidth = VECS[v].iw;
      cursorMode = VECS[v].cur; activeLow = VECS[v].low;
      runFrames(2, tagOf(VECS[v].req));
    end

    // R9: composite mode off while every window would be active
    hStart = 0; hWidth = 12; vStart = 0; vWidth = 6; irqStart = 0; irqWidth = 6;
    compositeMode = 0; cursorMode = 0; activeLow = 0;
    runFrames(1, "R9");
    activeLow = 1; cursorMode = 1;
    runFrames(1, "R9");
    compositeMode = 1; cursorMode = 0; activeLow = 0;

    // R4: mid-line rewrite of the line windows
    hStart = 0; hWidth = 12; vStart = 1; vWidth = 1; irqStart = 1; irqWidth = 1;
    for (int l = 0; l < 3; l++) begin
      for (int k = 0; k < LINE_LEN; k++) begin
        lineStart  = (k == 0);
        frameStart = (k == 0) && (l == 0);
        if (l == 1 && k == 5) begin
          vStart = 5; irqStart = 5;
        end
        if (l == 1 && k == 8) cursorMode = 1;
        tick();
        check("R4");
      end
    end
    lineStart = 0; frameStart = 0;
    // after the next line start both vertical windows must be off
    for (int k = 0; k < 3; k++) begin
      lineStart = (k == 0);
      tick();
      check("R4");
      if (k == 1) begin
        checks++;
        if (driveV !== 1'b0 || driveH !== 1'b0) begin
          fails++;
          $display("FAIL R4: driveH/driveV = %b/%b expected 0/0", driveH, driveV);
        end
      end
    end
    lineStart = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule